// File: doc/BRIEF.md
# MDIO PHY Auto-Poll Controller

This block watches a small set of Ethernet PHY management registers without help from software. It generates Clause 22 MDIO read frames on its own MDC/MDIO pins. It visits a fixed set of six polling slots in turn and keeps the last 16-bit value it read for each slot. When a freshly read value differs from the stored one, the block sets a per-slot change flag. An interrupt output is high while any change flag is set. The host reads the captured values through a slot selector and clears flags one bit at a time.

Slot 0 is fixed. It always reads register 1 of the default PHY, whose address comes in on a port, and it is always enabled. Slots 1 to 5 are set up by the host. Each has a PHY address, a register number, an enable bit, a preamble-skip bit and a use-default-PHY bit. A side input reports whether the default PHY accepts frames without a preamble. That input decides the preamble for slot 0 and for every slot that uses the default PHY. A global enable starts and stops polling. The host must clear the global enable, and let the current frame finish, before it changes any slot setting.

Top module: `mdio_autopoll`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_oe` is 0, `irq` is 0, every change flag is 0 and every captured value reads 0.
- R2: While `poll_en` is 0, no new read frame starts and the slot pointer returns to slot 0. The first frame after `poll_en` rises is therefore a slot 0 frame.
- R3: Enabled slots are read one complete frame at a time, in ascending slot order from 0 to 5, wrapping back to 0. Disabled slots are skipped. Slot 0 is always read.
- R4: A slot 0 frame carries PHY address `dflt_phy_addr` and register number 1. Its preamble is left out exactly when `dflt_no_pre_ok` is 1.
- R5: Every frame carries its fields in this order: 32 ones as preamble (unless skipped), start bits 0 then 1, opcode bits 1 then 0, the 5-bit PHY address MSB first, then the 5-bit register number MSB first. After these the block releases MDIO (`mdio_oe` = 0) for 2 turnaround bits and 16 data bits.
- R6: A user slot whose preamble-skip bit is 1 and whose use-default bit is 0 sends its frame with no preamble. With both bits 0, the frame has the full 32-bit preamble.
- R7: A user slot whose use-default bit is 1 sends to `dflt_phy_addr`, and its own address and preamble-skip bit have no effect. Its preamble is left out exactly when `dflt_no_pre_ok` is 1.
- R8: The 16 data bits are sampled from `mdio_i` on rising MDC edges, MSB first. They are stored for the slot and can be read on `rd_data` when `rd_sel` holds the slot number.
- R9: When a read completes with a value different from the stored one, the slot's change flag (bit n of `chg_flag` for slot n) is set. The flag stays set until the host pulses the matching `chg_clr` bit. A read that returns the stored value leaves the flag unchanged.
- R10: `irq` is 1 exactly when at least one change flag is set.
- R11: MDC has a period of 2*HALF_DIV system clocks. `mdio_o` changes only at a falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_en | input | 1 | Global polling enable |
| dflt_phy_addr | input | 5 | Default PHY address (slot 0 and default-PHY slots) |
| dflt_no_pre_ok | input | 1 | Default PHY accepts frames without preamble |
| user_phy_addr | input | 5*NUM_USER | PHY address of each user slot, slot 1 in the low bits |
| user_reg_addr | input | 5*NUM_USER | Register number of each user slot |
| user_en | input | NUM_USER | Enable of each user slot |
| user_no_pre | input | NUM_USER | Preamble-skip bit of each user slot |
| user_use_dflt | input | NUM_USER | Use-default-PHY bit of each user slot |
| chg_clr | input | NUM_USER+1 | One-cycle clear pulse per change flag |
| rd_sel | input | clog2(NUM_USER+1) | Slot whose captured value appears on rd_data |
| rd_data | output | 16 | Captured value of the selected slot |
| chg_flag | output | NUM_USER+1 | Per-slot change flags |
| irq | output | 1 | Host interrupt, OR of the change flags |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
The assertions assume that the PHY side drives `mdio_i` only while the block has released MDIO. They also assume that slot settings and `dflt_phy_addr` change only while `poll_en` is 0 and no frame is in flight. The assertion on change flags assumes that `chg_clr` is the only way a set flag falls.

The bench keeps within these assumptions. Its PHY model drives data only after the turnaround and returns `mdio_i` to 1 once a frame ends. It changes configuration only after dropping `poll_en` and waiting longer than a full preamble frame. It sweeps all 32 user-enable masks, alternating the default-PHY capability input between masks.

// File: rtl/mdio_ap_pkg.sv
// Package: shared constants and the read-request type of the MDIO auto-poll
// block. Assumes Clause 22 framing (5-bit addresses, 16-bit data).
package mdio_ap_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 14;
    localparam int TA_LEN    = 2;
    localparam int FRAME_LEN = PRE_LEN + HDR_LEN + TA_LEN + DATA_W;

    // One read request handed from the slot scheduler to the frame engine.
    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic              no_pre;
    } mdio_req_t;
endpackage

// File: rtl/mdio_ap_clkgen.sv
// MDC generator: divides the system clock so that MDC spends HALF_DIV clocks
// high and HALF_DIV clocks low. Raises rise_stb/fall_stb in the cycle whose
// closing edge makes MDC rise/fall. Assumes HALF_DIV >= 1. Runs free.
module mdio_ap_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap     = (cnt == CNT_TOP);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_MDC_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(rise_stb || fall_stb)); // R11
endmodule

// File: rtl/mdio_ap_frame.sv
// Frame engine: sends one Clause 22 read frame per start pulse. Drives
// MDIO at falling MDC strobes, releases it for turnaround and data, and
// shifts in 16 data bits MSB first at rising strobes. Pulses done for one
// cycle with rdata valid. Assumes start is raised only while busy is low.
module mdio_ap_frame
    import mdio_ap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              start,
    input  mdio_req_t         req,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam logic [6:0] POS_HDR  = 7'(PRE_LEN);
    localparam logic [6:0] POS_TA   = 7'(PRE_LEN + HDR_LEN);
    localparam logic [6:0] POS_END  = 7'(FRAME_LEN);
    localparam logic [5:0] POS_DATA = 6'(PRE_LEN + HDR_LEN + TA_LEN);
    localparam logic [5:0] POS_LAST = 6'(FRAME_LEN - 1);

    logic [6:0]         pos;
    logic [5:0]         cur;
    logic               drv;
    logic [HDR_LEN-1:0] hdr;

    // Bit value driven at frame position p: preamble ones, then header.
    function automatic logic bit_at(input logic [6:0] p, input logic [HDR_LEN-1:0] h);
        logic [6:0] k;
        k = (POS_TA - 7'd1) - p;
        if (p < POS_HDR)     return 1'b1;
        else if (p < POS_TA) return h[k[3:0]];
        else                 return 1'b1;
    endfunction

    // Frame sequencing: position counter, MDIO drive and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            drv     <= 1'b0;
            pos     <= '0;
            cur     <= '0;
            hdr     <= '0;
            rdata   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                drv  <= 1'b0;
                pos  <= req.no_pre ? POS_HDR : 7'd0;
                hdr  <= {4'b0110, req.phy, req.regad};
            end else if (busy) begin
                if (fall_stb && pos < POS_END) begin
                    mdio_o  <= bit_at(pos, hdr);
                    mdio_oe <= (pos < POS_TA);
                    cur     <= pos[5:0];
                    pos     <= pos + 7'd1;
                    drv     <= 1'b1;
                end
                if (rise_stb && drv && cur >= POS_DATA) begin
                    rdata <= {rdata[DATA_W-2:0], mdio_i};
                    if (cur == POS_LAST) begin
                        done <= 1'b1;
                        busy <= 1'b0;
                    end
                end
            end
        end
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R3
    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy); // R5
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $past(fall_stb)); // R11
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdio_oe); // R5
endmodule

// File: rtl/mdio_ap_sched.sv
// Slot scheduler and capture store: builds the effective request of each of
// the NUM_USER+1 slots (slot 0 fixed to register 1 of the default PHY), walks
// the enabled slots round-robin, stores each completed read, and keeps sticky
// change flags. Assumes configuration is stable while polling is enabled.
module mdio_ap_sched
    import mdio_ap_pkg::*;
#(
    parameter int NUM_USER = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          poll_en,
    input  logic [ADDR_W-1:0]             dflt_phy_addr,
    input  logic                          dflt_no_pre_ok,
    input  logic [NUM_USER*ADDR_W-1:0]    user_phy_addr,
    input  logic [NUM_USER*ADDR_W-1:0]    user_reg_addr,
    input  logic [NUM_USER-1:0]           user_en,
    input  logic [NUM_USER-1:0]           user_no_pre,
    input  logic [NUM_USER-1:0]           user_use_dflt,
    input  logic                          eng_busy,
    input  logic                          eng_done,
    input  logic [DATA_W-1:0]             eng_rdata,
    output logic                          start,
    output mdio_req_t                     req,
    input  logic [NUM_USER:0]             chg_clr,
    input  logic [$clog2(NUM_USER+1)-1:0] rd_sel,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NUM_USER:0]             chg_flag
);
    localparam int NUM_SLOT = NUM_USER + 1;
    localparam int IDX_W    = $clog2(NUM_SLOT);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_SLOT - 1);

    logic [ADDR_W-1:0] slot_phy [0:NUM_SLOT-1];
    logic [ADDR_W-1:0] slot_reg [0:NUM_SLOT-1];
    logic [NUM_SLOT-1:0] slot_np;
    logic [NUM_SLOT-1:0] slot_en;
    logic [DATA_W-1:0] store [0:NUM_SLOT-1];
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_nxt;
    logic [NUM_SLOT-1:0] set_vec;

    // Slot 0: default PHY, status register, always enabled.
    assign slot_phy[0] = dflt_phy_addr;
    assign slot_reg[0] = ADDR_W'(1);
    assign slot_np[0]  = dflt_no_pre_ok;
    assign slot_en[0]  = 1'b1;

    // User slots: default-PHY flag overrides address and preamble choice.
    for (genvar g = 1; g < NUM_SLOT; g++) begin : g_user
        assign slot_phy[g] = user_use_dflt[g-1] ? dflt_phy_addr
                                                : user_phy_addr[(g-1)*ADDR_W +: ADDR_W];
        assign slot_reg[g] = user_reg_addr[(g-1)*ADDR_W +: ADDR_W];
        assign slot_np[g]  = user_use_dflt[g-1] ? dflt_no_pre_ok : user_no_pre[g-1];
        assign slot_en[g]  = user_en[g-1];
    end

    assign idx_nxt = (idx == IDX_TOP) ? '0 : idx + 1'b1;
    assign start   = poll_en && !eng_busy && !eng_done && slot_en[idx];

    // Request presented to the frame engine for the current slot.
    always_comb begin
        req.phy    = slot_phy[idx];
        req.regad  = slot_reg[idx];
        req.no_pre = slot_np[idx];
    end

    // Change detection of a completed read against the stored value.
    always_comb begin
        set_vec = '0;
        if (eng_done && eng_rdata != store[idx]) set_vec[idx] = 1'b1;
    end

    // Host read port onto the capture store.
    always_comb begin
        rd_data = '0;
        if (rd_sel <= IDX_TOP) rd_data = store[rd_sel];
    end

    // Slot pointer, capture store and sticky change flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            chg_flag <= '0;
            for (int i = 0; i < NUM_SLOT; i++) store[i] <= '0;
        end else begin
            chg_flag <= (chg_flag & ~chg_clr) | set_vec;
            if (eng_done) begin
                store[idx] <= eng_rdata;
                idx        <= idx_nxt;
            end else if (!eng_busy && !poll_en) begin
                idx <= '0;
            end else if (!eng_busy && !slot_en[idx]) begin
                idx <= idx_nxt;
            end
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_en && !eng_busy |=> !eng_busy); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(chg_flag) & ~$past(chg_clr) & ~chg_flag) == '0)); // R9
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_TOP); // R3
endmodule

// File: rtl/mdio_autopoll.sv
// Top of the MDIO auto-poll controller: MDC generator, frame engine and slot
// scheduler. Polls NUM_USER+1 PHY registers round-robin over Clause 22
// reads and interrupts the host on a change. Assumes the host freezes the
// configuration while poll_en is high.
module mdio_autopoll
    import mdio_ap_pkg::*;
#(
    parameter int NUM_USER = 5,
    parameter int HALF_DIV = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          poll_en,
    input  logic [ADDR_W-1:0]             dflt_phy_addr,
    input  logic                          dflt_no_pre_ok,
    input  logic [NUM_USER*ADDR_W-1:0]    user_phy_addr,
    input  logic [NUM_USER*ADDR_W-1:0]    user_reg_addr,
    input  logic [NUM_USER-1:0]           user_en,
    input  logic [NUM_USER-1:0]           user_no_pre,
    input  logic [NUM_USER-1:0]           user_use_dflt,
    input  logic [NUM_USER:0]             chg_clr,
    input  logic [$clog2(NUM_USER+1)-1:0] rd_sel,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NUM_USER:0]             chg_flag,
    output logic                          irq,
    output logic                          mdc,
    output logic                          mdio_o,
    output logic                          mdio_oe,
    input  logic                          mdio_i
);
    logic              rise_stb;
    logic              fall_stb;
    logic              start;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rdata;
    mdio_req_t         req;

    mdio_ap_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_ap_frame u_frame (
        .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .start(start), .req(req), .busy(eng_busy), .done(eng_done),
        .rdata(eng_rdata), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    mdio_ap_sched #(.NUM_USER(NUM_USER)) u_sched (
        .clk(clk), .rst_n(rst_n), .poll_en(poll_en),
        .dflt_phy_addr(dflt_phy_addr), .dflt_no_pre_ok(dflt_no_pre_ok),
        .user_phy_addr(user_phy_addr), .user_reg_addr(user_reg_addr),
        .user_en(user_en), .user_no_pre(user_no_pre), .user_use_dflt(user_use_dflt),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_rdata(eng_rdata),
        .start(start), .req(req), .chg_clr(chg_clr), .rd_sel(rd_sel),
        .rd_data(rd_data), .chg_flag(chg_flag)
    );

    assign irq = |chg_flag;

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(eng_done)); // R10
endmodule

// File: tb/mdio_autopoll_tb.sv
`timescale 1ns/1ps
module mdio_autopoll_tb;
    localparam int NU = 5;
    localparam int NS = NU + 1;
    localparam int HD = 2;
    localparam int LOGN = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic poll_en = 1'b0;
    logic [4:0] dflt_phy_addr = 5'd5;
    logic dflt_no_pre_ok = 1'b0;
    logic [NU*5-1:0] user_phy_addr, user_reg_addr;
    logic [NU-1:0] user_en = '0, user_no_pre, user_use_dflt;
    logic [NU:0] chg_clr = '0;
    logic [2:0] rd_sel = '0;
    logic [15:0] rd_data;
    logic [NU:0] chg_flag;
    logic irq, mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    int checks = 0, errors = 0;
    int fcount = 0, oe_bad = 0, bad_edge = 0;
    int fr_phy [LOGN];
    int fr_reg [LOGN];
    int fr_nd  [LOGN];
    int fr_ok  [LOGN];
    int bump_reg = 31;
    int epoch = 0;

    always #2 clk = !clk;

    mdio_autopoll #(.NUM_USER(NU), .HALF_DIV(HD)) u_dut (
        .clk(clk), .rst_n(rst_n), .poll_en(poll_en),
        .dflt_phy_addr(dflt_phy_addr), .dflt_no_pre_ok(dflt_no_pre_ok),
        .user_phy_addr(user_phy_addr), .user_reg_addr(user_reg_addr),
        .user_en(user_en), .user_no_pre(user_no_pre), .user_use_dflt(user_use_dflt),
        .chg_clr(chg_clr), .rd_sel(rd_sel), .rd_data(rd_data),
        .chg_flag(chg_flag), .irq(irq), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic logic [15:0] model(input int phy, input int rg);
        logic [15:0] v;
        v = {5'(phy), 5'(rg), 6'd0};
        if (rg == bump_reg) v = v ^ 16'(epoch & 63);
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // PHY model: logs each frame header, then returns register data.
    initial begin
        logic [13:0] hist;
        int nd;
        logic [15:0] val;
        hist = '0; nd = 0;
        forever begin
            @(posedge mdc); #1;
            if (mdio_oe) begin
                hist = {hist[12:0], mdio_o};
                nd++;
            end else if (nd > 0) begin
                fr_phy[fcount % LOGN] = int'(hist[9:5]);
                fr_reg[fcount % LOGN] = int'(hist[4:0]);
                fr_nd[fcount % LOGN]  = nd;
                fr_ok[fcount % LOGN]  = (hist[13:10] == 4'b0110) ? 1 : 0;
                fcount++;
                val = model(int'(hist[9:5]), int'(hist[4:0]));
                @(posedge mdc); #1;
                if (mdio_oe) oe_bad++;
                for (int k = 15; k >= 0; k--) begin
                    mdio_i = val[k];
                    @(posedge mdc); #1;
                    if (mdio_oe) oe_bad++;
                end
                mdio_i = 1'b1;
                nd = 0;
            end
        end
    end

    // Monitor: mdio_o may only change together with a falling MDC.
    logic prev_o = 1'b1, prev_mdc = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mdio_o !== prev_o && !(prev_mdc == 1'b1 && mdc == 1'b0)) bad_edge++;
        prev_o = mdio_o;
        prev_mdc = mdc;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic stop_poll();
        @(negedge clk); poll_en = 1'b0;
        repeat (320) @(negedge clk);
    endtask

    task automatic wait_frames(input int target);
        int t;
        t = 0;
        while (fcount < target && t < 20000) begin @(negedge clk); t++; end
    endtask

    function automatic int slot_phy(input int s);
        if (s == 0 || user_use_dflt[s-1]) return int'(dflt_phy_addr);
        return int'(user_phy_addr[(s-1)*5 +: 5]);
    endfunction
    function automatic int slot_reg(input int s);
        if (s == 0) return 1;
        return int'(user_reg_addr[(s-1)*5 +: 5]);
    endfunction
    function automatic int slot_pre(input int s);
        if (s == 0 || user_use_dflt[s-1]) return dflt_no_pre_ok ? 0 : 32;
        return user_no_pre[s-1] ? 0 : 32;
    endfunction

    // Run one mask, compare frame order and contents, then captured data.
    task automatic run_mask(input int mask, input string tag);
        int en_list [NS];
        int n, base, k;
        n = 0;
        for (int s = 0; s < NS; s++)
            if (s == 0 || mask[s-1]) begin en_list[n] = s; n++; end
        k = n + 2;
        @(negedge clk);
        user_en = NU'(mask);
        base = fcount;
        poll_en = 1'b1;
        wait_frames(base + k);
        stop_poll();
        for (int j = 0; j < k; j++) begin
            int s, idx;
            logic good;
            s = en_list[j % n];
            idx = (base + j) % LOGN;
            good = fr_phy[idx] == slot_phy(s) && fr_reg[idx] == slot_reg(s) &&
                   fr_nd[idx] == slot_pre(s) + 14 && fr_ok[idx] == 1;
            checks++;
            if (!good) begin
                errors++;
                $display("FAIL %s mask %0d frame %0d: actual phy %0d reg %0d bits %0d ok %0d expected phy %0d reg %0d bits %0d ok 1",
                         tag, mask, j, fr_phy[idx], fr_reg[idx], fr_nd[idx], fr_ok[idx],
                         slot_phy(s), slot_reg(s), slot_pre(s) + 14);
            end
        end
        for (int j = 0; j < n; j++) begin
            rd_sel = 3'(en_list[j]);
            @(negedge clk);
            check("R8 captured value", rd_data, model(slot_phy(en_list[j]), slot_reg(en_list[j])));
        end
    endtask

    initial begin
        realtime t1, t2;
        for (int i = 1; i <= NU; i++) begin
            user_phy_addr[(i-1)*5 +: 5] = 5'(10 + i);
            user_reg_addr[(i-1)*5 +: 5] = 5'(16 + i);
            user_no_pre[i-1]   = (i % 2) == 1;
            user_use_dflt[i-1] = (i == 4);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mdio_oe", mdio_oe, 0);
        check("R1 irq", irq, 0);
        check("R1 flags", chg_flag, 0);
        for (int s = 0; s < NS; s++) begin
            rd_sel = 3'(s); #1;
            check("R1 captured value", rd_data, 0);
        end
        // R11 MDC period
        @(posedge mdc); t1 = $realtime;
        @(posedge mdc); t2 = $realtime;
        check("R11 mdc period ns", longint'(t2 - t1), 4 * 2 * HD);
        // R2 nothing while disabled
        repeat (600) @(negedge clk);
        check("R2 no frame while disabled", fcount, 0);
        // Slot 0 only, preamble on: first read also sets flag from 0
        run_mask(0, "R4 R5 slot0");
        check("R9 flag set on first change", chg_flag[0], 1);
        check("R10 irq with flag", irq, 1);
        // Sweep every user-enable mask, capability toggled per mask
        for (int m = 0; m < 32; m++) begin
            dflt_no_pre_ok = m[0];
            run_mask(m, "R2 R3 R6 R7");
        end
        // Clear all flags
        @(negedge clk); chg_clr = '1;
        @(negedge clk); chg_clr = '0;
        @(negedge clk);
        check("R9 cleared flags", chg_flag, 0);
        check("R10 irq after clear", irq, 0);
        // Repeat reads with unchanged values: no flag
        run_mask(31, "R3 unchanged");
        check("R9 unchanged read keeps flags", chg_flag, 0);
        check("R10 irq stays low", irq, 0);
        // Change only slot 2's register value
        bump_reg = 18; epoch = 5;
        run_mask(31, "R8 bump");
        check("R9 only slot 2 flagged", chg_flag, 7'b0000100);
        check("R10 irq on change", irq, 1);
        repeat (50) @(negedge clk);
        check("R9 flag sticky", chg_flag, 7'b0000100);
        @(negedge clk); chg_clr = 6'b000001 << 2;
        @(negedge clk); chg_clr = '0;
        @(negedge clk);
        check("R9 single clear", chg_flag, 0);
        check("R5 mdio released during turnaround/data", oe_bad, 0);
        check("R11 mdio_o changes only on falling mdc", bad_edge, 0);
        summary();
    end
endmodule